// File: doc/BRIEF.md
# DRAM Row and Hole Address Decoder

This block takes a physical address and decides which of eight DRAM rows (chip-select groups) owns it. Eight byte-wide boundary registers each hold a running total of installed memory, in 8 MB units. Register n holds the combined size of rows 0 through n. A lookup selects the lowest row whose boundary, scaled to bytes, lies above the address.

A row with no memory repeats the total of the row below it, so it can never be picked. A 2-bit hole code can carve out one fixed window, either 512–640 KB or 15–16 MB. Addresses in that window are not claimed by DRAM.

Software loads the registers through a byte-wide write port. The memory pipeline then presents addresses with a valid strobe. One cycle later the block returns a registered one-hot row select, a hit flag and a miss flag. All boundaries reset to zero, so every address misses until the registers are loaded.

Top module: `dram_row_decoder`

## Requirements
- R1: When `cfg_we` is high, `cfg_wdata` is written to boundary register `cfg_sel` for `cfg_sel` values 0 to 7. After reset all boundaries read as zero, so every lookup misses.
- R2: For a valid address A, row n is selected, with `row_sel` bit n high and `hit` high, when n is the lowest index for which A < boundary[n] × 8 MB.
- R3: A row whose boundary equals the boundary of the row below it (an empty row) is never selected.
- R4: An address at or above every boundary × 8 MB returns `miss` high, `hit` low and `row_sel` zero.
- R5: Bits [1:0] of the control register at `cfg_sel` = 8 hold the hole code. Code 00 means no hole. Code 01 carves out addresses 0x80000 to 0x9FFFF. Code 10 carves out addresses 0xF00000 to 0xFFFFFF. An address inside the active hole returns `miss` with `row_sel` zero, even when it lies below a boundary.
- R6: Hole code 11 is reserved and behaves like code 00: neither window is carved out.
- R7: Every result is registered. `result_valid`, `row_sel`, `hit` and `miss` reflect the address presented with `addr_valid` at the previous rising clock edge. Lookups may be issued every cycle. When no lookup was presented, all four outputs are zero.
- R8: While `result_valid` is high, exactly one of `hit` and `miss` is high, and `row_sel` has one bit set on a hit and none on a miss.
- R9: Writes with `cfg_sel` values 9 to 15 are ignored. They change no boundary and not the hole code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register index: 0–7 boundaries, 8 hole control |
| cfg_wdata | input | 8 | Register write data |
| addr_valid | input | 1 | Lookup strobe |
| addr | input | 32 | Physical byte address to decode |
| result_valid | output | 1 | Result of the previous cycle's lookup is present |
| row_sel | output | 8 | One-hot selected row |
| hit | output | 1 | Address is claimed by a DRAM row |
| miss | output | 1 | Address is above top of memory or in the active hole |

## Verification
Each lookup result appears exactly one clock edge after the lookup is presented. A register write takes effect at the edge that captures it, so a lookup issued in a later cycle sees the new value.

The bench drives lookups on falling edges and pushes the expected result into a queue at the same moment. The monitor pops that entry on the following falling edge, by which time the result has been captured. Back-to-back lookups therefore line up one-to-one with queue entries. On every falling edge with no result pending, the monitor checks that the outputs are all zero.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  localparam int unsigned HOLE_W = 2;

  typedef enum logic [HOLE_W-1:0] {
    HOLE_NONE = 2'b00,
    HOLE_LOW  = 2'b01,
    HOLE_HIGH = 2'b10,
    HOLE_RSVD = 2'b11
  } hole_mode_e;

  // carve-out windows, byte addresses, end exclusive
  localparam logic [31:0] LOW_HOLE_BASE  = 32'h0008_0000;
  localparam logic [31:0] LOW_HOLE_END   = 32'h000A_0000;
  localparam logic [31:0] HIGH_HOLE_BASE = 32'h00F0_0000;
  localparam logic [31:0] HIGH_HOLE_END  = 32'h0100_0000;
endpackage

// File: rtl/dram_bnd_regs.sv
module dram_bnd_regs
  import dram_dec_pkg::*;
#(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned BND_W = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic [BND_W-1:0]                cfg_wdata,
  output logic [ROWS-1:0][BND_W-1:0]      bnd,
  output hole_mode_e                      hole_code
);
  localparam logic [SEL_W-1:0] CTRL_IDX = SEL_W'(ROWS);

  logic [ROWS-1:0][BND_W-1:0] bnd_d, bnd_q;
  logic [ROWS-1:0]            bnd_en;
  hole_mode_e                 hole_d, hole_q;
  logic                       hole_en;

  // write enables per register; unmapped indices match nothing
  always_comb begin
    for (int n = 0; n < ROWS; n++) begin
      bnd_en[n] = cfg_we && (cfg_sel == SEL_W'(n));
      bnd_d[n]  = bnd_en[n] ? cfg_wdata : bnd_q[n];
    end
    hole_en = cfg_we && (cfg_sel == CTRL_IDX);
    hole_d  = hole_en ? hole_mode_e'(cfg_wdata[HOLE_W-1:0]) : hole_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q  <= '0;
      hole_q <= HOLE_NONE;
    end else begin
      if (|bnd_en) bnd_q  <= bnd_d;
      if (hole_en) hole_q <= hole_d;
    end
  end

  assign bnd       = bnd_q;
  assign hole_code = hole_q;
endmodule

// File: rtl/dram_row_match.sv
module dram_row_match #(
  parameter int unsigned ROWS      = 8,
  parameter int unsigned BND_W     = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LOG2 = 23
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ROWS-1:0][BND_W-1:0] bnd,
  output logic [ROWS-1:0]            row_onehot,
  output logic                       any_row
);
  localparam int unsigned PAGE_W = ADDR_W - GRAN_LOG2;
  localparam int unsigned CMP_W  = (PAGE_W > BND_W) ? PAGE_W : BND_W;

  logic [CMP_W-1:0] addr_units;
  logic [ROWS-1:0]  below;
  logic [ROWS:0]    taken;

  assign addr_units = CMP_W'(addr[ADDR_W-1:GRAN_LOG2]);
  assign taken[0]   = 1'b0;

  // lowest row whose running total exceeds the address wins
  for (genvar n = 0; n < ROWS; n++) begin : g_row
    assign below[n]      = addr_units < CMP_W'(bnd[n]);
    assign row_onehot[n] = below[n] & ~taken[n];
    assign taken[n+1]    = taken[n] | below[n];
  end

  assign any_row = taken[ROWS];
endmodule

// File: rtl/dram_hole_check.sv
module dram_hole_check
  import dram_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  hole_mode_e        hole_code,
  output logic              in_hole
);
  localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LOW_HOLE_BASE);
  localparam logic [ADDR_W-1:0] LO_E = ADDR_W'(LOW_HOLE_END);
  localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HIGH_HOLE_BASE);
  localparam logic [ADDR_W-1:0] HI_E = ADDR_W'(HIGH_HOLE_END);

  logic in_low, in_high;

  assign in_low  = (addr >= LO_B) && (addr < LO_E);
  assign in_high = (addr >= HI_B) && (addr < HI_E);

  always_comb begin
    unique case (hole_code)
      HOLE_LOW:  in_hole = in_low;
      HOLE_HIGH: in_hole = in_high;
      default:   in_hole = 1'b0;  // none and reserved
    endcase
  end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import dram_dec_pkg::*;
#(
  parameter int unsigned ROWS      = 8,
  parameter int unsigned BND_W     = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LOG2 = 23
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(ROWS+1)-1:0]    cfg_sel,
  input  logic [BND_W-1:0]             cfg_wdata,
  input  logic                         addr_valid,
  input  logic [ADDR_W-1:0]            addr,
  output logic                         result_valid,
  output logic [ROWS-1:0]              row_sel,
  output logic                         hit,
  output logic                         miss
);
  localparam int unsigned SEL_W = $clog2(ROWS+1);

  logic [ROWS-1:0][BND_W-1:0] bnd;
  hole_mode_e                 hole_code;
  logic [ROWS-1:0]            row_onehot;
  logic                       any_row;
  logic                       in_hole;

  logic                       vld_d, vld_q;
  logic [ROWS-1:0]            sel_d, sel_q;
  logic                       hit_d, hit_q;
  logic                       miss_d, miss_q;

  dram_bnd_regs #(.ROWS(ROWS), .BND_W(BND_W), .SEL_W(SEL_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .bnd       (bnd),
    .hole_code (hole_code)
  );

  dram_row_match #(.ROWS(ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W),
                   .GRAN_LOG2(GRAN_LOG2)) i_match (
    .addr       (addr),
    .bnd        (bnd),
    .row_onehot (row_onehot),
    .any_row    (any_row)
  );

  dram_hole_check #(.ADDR_W(ADDR_W)) i_hole (
    .addr      (addr),
    .hole_code (hole_code),
    .in_hole   (in_hole)
  );

  always_comb begin
    vld_d  = addr_valid;
    sel_d  = '0;
    hit_d  = 1'b0;
    miss_d = 1'b0;
    if (addr_valid) begin
      hit_d  = any_row & ~in_hole;
      miss_d = ~hit_d;
      sel_d  = hit_d ? row_onehot : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sel_q  <= '0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      sel_q  <= sel_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign result_valid = vld_q;
  assign row_sel      = sel_q;
  assign hit          = hit_q;
  assign miss         = miss_q;
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk
  import dram_dec_pkg::*;
#(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input hole_mode_e        hole_code,
  input logic              result_valid,
  input logic [ROWS-1:0]   row_sel,
  input logic              hit,
  input logic              miss
);
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $onehot0(row_sel));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (hit != miss));

  assert_hit_has_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (hit == (row_sel != '0)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> (row_sel == '0 && !hit && !miss));

  assert_hole_excluded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && hit) |->
      !(($past(hole_code) == HOLE_LOW &&
         $past(addr) >= ADDR_W'(LOW_HOLE_BASE) && $past(addr) < ADDR_W'(LOW_HOLE_END)) ||
        ($past(hole_code) == HOLE_HIGH &&
         $past(addr) >= ADDR_W'(HIGH_HOLE_BASE) && $past(addr) < ADDR_W'(HIGH_HOLE_END))));
endmodule

bind dram_row_decoder dram_row_decoder_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .hole_code    (hole_code),
  .result_valid (result_valid),
  .row_sel      (row_sel),
  .hit          (hit),
  .miss         (miss)
);

// File: tb/test_dram_row_decoder.sv
module test_dram_row_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        addr_valid = 1'b0;
  logic [31:0] addr = '0;
  logic        result_valid;
  logic [7:0]  row_sel;
  logic        hit, miss;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_bnd [8];
  logic [1:0] m_hole;
  logic [9:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  dram_row_decoder i_dram_row_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_valid(addr_valid), .addr(addr),
    .result_valid(result_valid), .row_sel(row_sel), .hit(hit), .miss(miss)
  );

  function automatic logic [9:0] model(input logic [31:0] a);
    logic [7:0] sel;
    logic found;
    logic hole;
    sel = '0;
    found = 1'b0;
    for (int n = 0; n < 8; n++)
      if (!found && ({1'b0, a[31:23]} < {2'b0, m_bnd[n]})) begin
        sel[n] = 1'b1;
        found = 1'b1;
      end
    hole = (m_hole == 2'b01 && a >= 32'h80000 && a < 32'hA0000) ||
           (m_hole == 2'b10 && a >= 32'hF00000 && a < 32'h1000000);
    if (hole) begin
      sel = '0;
      found = 1'b0;
    end
    return {sel, found, ~found};
  endfunction

  task automatic cfg_write(input logic [3:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    if (sel < 4'd8) m_bnd[sel[2:0]] = data;
    else if (sel == 4'd8) m_hole = data[1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    @(negedge clk);
    addr_valid = 1'b1; addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    addr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic program_bnd(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    cfg_write(4'd0, b0); cfg_write(4'd1, b1); cfg_write(4'd2, b2); cfg_write(4'd3, b3);
    cfg_write(4'd4, b4); cfg_write(4'd5, b5); cfg_write(4'd6, b6); cfg_write(4'd7, b7);
  endtask

  // monitor: pops one expected item per produced result
  always @(negedge clk) begin
    if (rst_n) begin
      if (result_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected result: got sel=%h hit=%b miss=%b expected none",
                   row_sel, hit, miss);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({row_sel, hit, miss} !== e) begin
            failures++;
            $display("FAIL %s got sel=%h hit=%b miss=%b expected sel=%h hit=%b miss=%b",
                     t, row_sel, hit, miss, e[9:2], e[1], e[0]);
          end
        end
      end else begin
        checks++;
        if (row_sel !== '0 || hit !== 1'b0 || miss !== 1'b0) begin
          failures++;
          $display("FAIL R7 idle outputs got sel=%h hit=%b miss=%b expected zeros",
                   row_sel, hit, miss);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) m_bnd[n] = '0;
    m_hole = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R7 reset state
    if (result_valid !== 1'b0 || row_sel !== '0) begin
      failures++;
      $display("FAIL R7 reset state got v=%b sel=%h expected 0 0", result_valid, row_sel);
    end

    // R1: unprogrammed boundaries miss everything
    lookup(32'h0000_0000, "R1");
    lookup(32'h7FFF_FFFF, "R1");
    idle();

    // single 64 MB module in the first row, rows 1..7 empty
    program_bnd(8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08);
    lookup(32'h0000_0000, "R2");
    lookup(32'h03FF_FFFF, "R3");
    lookup(32'h0400_0000, "R4");
    lookup(32'hFFFF_FFFF, "R4");
    idle();

    // mixed sizes with empty rows 1,3,4,6
    program_bnd(8'h02, 8'h02, 8'h05, 8'h05, 8'h05, 8'h09, 8'h09, 8'hFF);
    lookup(32'h00FF_FFFF, "R2");
    lookup(32'h0100_0000, "R3");
    lookup(32'h0280_0000, "R2");
    lookup(32'h0480_0000, "R2");
    lookup(32'h7F7F_FFFF, "R2");
    lookup(32'h7F80_0000, "R4");
    idle();

    // low hole
    cfg_write(4'd8, 8'h01);
    lookup(32'h0007_FFFF, "R5");
    lookup(32'h0008_0000, "R5");
    lookup(32'h0009_FFFF, "R5");
    lookup(32'h000A_0000, "R5");
    lookup(32'h00F0_0000, "R5");
    idle();

    // high hole
    cfg_write(4'd8, 8'h02);
    lookup(32'h00EF_FFFF, "R5");
    lookup(32'h00F0_0000, "R5");
    lookup(32'h00FF_FFFF, "R5");
    lookup(32'h0100_0000, "R5");
    lookup(32'h0009_0000, "R5");
    idle();

    // reserved code behaves as no hole
    cfg_write(4'd8, 8'h03);
    lookup(32'h0009_0000, "R6");
    lookup(32'h00F0_0000, "R6");
    idle();

    cfg_write(4'd8, 8'h00);
    lookup(32'h0009_0000, "R5");
    lookup(32'h00F8_0000, "R5");
    idle();

    // R9: unmapped indices must alias neither boundaries nor the hole code
    cfg_write(4'd9, 8'h01);
    cfg_write(4'd15, 8'h02);
    cfg_write(4'd10, 8'h00);
    lookup(32'h0009_0000, "R9");
    lookup(32'h0100_0000, "R9");
    lookup(32'h00F0_0000, "R9");
    lookup(32'h0000_0000, "R9");
    idle();

    // R1: rewrite one boundary and see the change
    cfg_write(4'd0, 8'h01);
    lookup(32'h0080_0000, "R1");
    lookup(32'h007F_FFFF, "R1");
    idle();
    idle();

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R7 missing results got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule